// File: doc/BRIEF.md
# Lookup-Routed Four-Port Packet Linecard

This block takes fixed-size 80-bit packets on one input and sends each of them to one of four output queues. The destination is not taken from the packet itself. For each packet, the block sends its 16-bit address to an external lookup engine through a request/response handshake. Responses come back in the order the requests were made, but their latency varies.

While a lookup is in flight, the packet waits in a pending queue. When the matching response arrives, the finish step moves the packet at the head of that queue into the output queue the response names. The pending queue depth is a parameter. It should cover the engine latency so that several lookups overlap and the input keeps streaming.

Each output drains through its own valid/take handshake. A table-write port passes index and data straight through to the lookup engine.

Top module: `pkt_lookup_router`

## Requirements
- R1: After reset the input is ready, no lookup request is valid, no output port is valid and no lookup response is accepted.
- R2: A packet carries its address in bits [79:64] and its payload in bits [63:0]. The lookup request address is bits [79:64] of the oldest packet that has not yet been looked up.
- R3: Every accepted input packet produces exactly one lookup request, and requests are issued in packet arrival order.
- R4: A response value of 0, 1, 2 or 3 sends the oldest pending packet, unchanged, to output port 0, 1, 2 or 3 respectively.
- R5: Packets leaving any one output port keep their arrival order, and no packet is lost or duplicated under random engine stalls, random latencies and random output draining.
- R6: While the output queue named by the head response is full, the response is not accepted. The packets already held stay valid, and they are all delivered once that port drains.
- R7: While a lookup request is valid but not accepted, it stays valid with an unchanged address.
- R8: With no responses returned, at most PEND_DEPTH lookups are outstanding, and the input accepts at most PEND_DEPTH + IN_DEPTH packets.
- R9: The table-write strobe, 12-bit index and 12-bit data appear unchanged on the engine-side table outputs in the same cycle.
- R10: With an always-ready engine that answers one cycle after each request and outputs that always drain, a back-to-back stream of 100 packets sees the input stall in no more than 10 cycles.
- R11: An output port that is valid but not taken stays valid with the same packet on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input packet valid |
| in_rdy | output | 1 | Input can accept a packet |
| in_pkt | input | 80 | Input packet, address in [79:64] |
| lk_req_vld | output | 1 | Lookup request valid |
| lk_req_rdy | input | 1 | Lookup engine accepts a request |
| lk_req_addr | output | 16 | Address to look up |
| lk_rsp_vld | input | 1 | Lookup response valid |
| lk_rsp_rdy | output | 1 | Block accepts the response |
| lk_rsp_port | input | 2 | Destination port from the engine |
| out_vld | output | 4 | Per-port packet valid |
| out_take | input | 4 | Per-port dequeue enable |
| out_pkt | output | 320 | Per-port head packet, port p in bits [80p+79:80p] |
| tbl_wr | input | 1 | Table-write strobe |
| tbl_idx | input | 12 | Table entry index |
| tbl_dat | input | 12 | Table entry data |
| lk_tbl_wr | output | 1 | Forwarded table-write strobe |
| lk_tbl_idx | output | 12 | Forwarded table index |
| lk_tbl_dat | output | 12 | Forwarded table data |

## Verification
The start step and the finish step can act in the same cycle. Both touch the pending queue: one pushes a new packet while the other pops the oldest. A bench-side engine model is ready at random, answers after 1 to 5 cycles and stalls at random, and the outputs drain at random, so pushes and pops of the pending queue keep meeting in the same cycle, including while the queue is full or nearly empty. The scoreboard judges the result per port: each leaving packet must equal the next one predicted for that port, and the request addresses must arrive in the predicted order.

// File: rtl/pkt_lookup_router_q.sv
module pkt_lookup_router_q #(
  parameter int W     = 80,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd, wr;
  logic [CW-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign dout  = mem[rd];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd  <= '0;
      wr  <= '0;
      cnt <= '0;
    end else begin
      if (push) wr <= nxt(wr);
      if (pop)  rd <= nxt(rd);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) if (push) mem[wr] <= din;

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/pkt_lookup_router.sv
module pkt_lookup_router #(
  parameter int PKT_W      = 80,
  parameter int ADDR_W     = 16,
  parameter int PORTS      = 4,
  parameter int IN_DEPTH   = 2,
  parameter int PEND_DEPTH = 4,
  parameter int OUT_DEPTH  = 2,
  parameter int TBL_W      = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_vld,
  output logic                   in_rdy,
  input  logic [79:0]            in_pkt,
  output logic                   lk_req_vld,
  input  logic                   lk_req_rdy,
  output logic [15:0]            lk_req_addr,
  input  logic                   lk_rsp_vld,
  output logic                   lk_rsp_rdy,
  input  logic [1:0]             lk_rsp_port,
  output logic [3:0]             out_vld,
  input  logic [3:0]             out_take,
  output logic [319:0]           out_pkt,
  input  logic                   tbl_wr,
  input  logic [11:0]            tbl_idx,
  input  logic [11:0]            tbl_dat,
  output logic                   lk_tbl_wr,
  output logic [11:0]            lk_tbl_idx,
  output logic [11:0]            lk_tbl_dat
);
  localparam int PW = $clog2(PORTS);

  logic [PKT_W-1:0] iq_dout, pq_dout;
  logic             iq_empty, iq_full, pq_empty, pq_full;
  logic             start, finish;
  logic [PORTS-1:0] oq_full, oq_empty;

  assign in_rdy = !iq_full;

  pkt_lookup_router_q #(.W(PKT_W), .DEPTH(IN_DEPTH)) u_inq (
    .clk(clk), .rst_n(rst_n), .push(in_vld && in_rdy), .din(in_pkt),
    .pop(start), .dout(iq_dout), .empty(iq_empty), .full(iq_full));

  assign lk_req_vld  = !iq_empty && !pq_full;
  assign lk_req_addr = iq_dout[PKT_W-1 -: ADDR_W];
  assign start       = lk_req_vld && lk_req_rdy;

  pkt_lookup_router_q #(.W(PKT_W), .DEPTH(PEND_DEPTH)) u_pendq (
    .clk(clk), .rst_n(rst_n), .push(start), .din(iq_dout),
    .pop(finish), .dout(pq_dout), .empty(pq_empty), .full(pq_full));

  assign lk_rsp_rdy = !pq_empty && !oq_full[lk_rsp_port];
  assign finish     = lk_rsp_vld && lk_rsp_rdy;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [PKT_W-1:0] head;
    pkt_lookup_router_q #(.W(PKT_W), .DEPTH(OUT_DEPTH)) u_outq (
      .clk(clk), .rst_n(rst_n),
      .push(finish && (lk_rsp_port == PW'(p))), .din(pq_dout),
      .pop(out_vld[p] && out_take[p]), .dout(head),
      .empty(oq_empty[p]), .full(oq_full[p]));
    assign out_vld[p] = !oq_empty[p];
    assign out_pkt[p*PKT_W +: PKT_W] = head;

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[p] && !out_take[p] |=> out_vld[p] && $stable(out_pkt[p*PKT_W +: PKT_W]));
  end

  assign lk_tbl_wr  = tbl_wr;
  assign lk_tbl_idx = tbl_idx;
  assign lk_tbl_dat = tbl_dat;

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req_vld && !lk_req_rdy |=> lk_req_vld && $stable(lk_req_addr));
  // R4
  route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> out_vld[$past(lk_rsp_port)]);
  // R3
  pend_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !pq_empty);
endmodule

// File: tb/pkt_lookup_router_tb.sv
`timescale 1ns/1ps
module pkt_lookup_router_tb;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic in_vld = 0, lk_req_rdy = 0, lk_rsp_vld = 0, tbl_wr = 0;
  logic [79:0] in_pkt = '0;
  logic [1:0] lk_rsp_port = '0;
  logic [3:0] out_take = '0;
  logic [11:0] tbl_idx = '0, tbl_dat = '0;
  logic in_rdy, lk_req_vld, lk_rsp_rdy, lk_tbl_wr;
  logic [15:0] lk_req_addr;
  logic [3:0] out_vld;
  logic [319:0] out_pkt;
  logic [11:0] lk_tbl_idx, lk_tbl_dat;

  pkt_lookup_router u_dut (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit run = 0, rand_busy = 0, rand_lat = 0, rand_take = 0, rsp_hold = 0, seen_stall = 0;
  logic [3:0] take_block = '0;
  int stall_cnt = 0, req_cnt = 0, acc_cnt = 0;

  logic [79:0] send_q [$];
  logic [79:0] exp_q [4][$];
  logic [15:0] addr_q [$];
  logic [1:0]  eng_port [$];
  int          eng_due [$];

  bit prev_req_stall = 0;
  logic [15:0] prev_addr;
  logic [3:0] prev_out_stall = '0;
  logic [79:0] prev_out [4];

  function automatic logic [1:0] route_of(input logic [15:0] a);
    return a[1:0] ^ a[9:8];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] a, input logic [63:0] pl);
    send_q.push_back({a, pl});
  endtask

  function automatic bit all_empty();
    return send_q.size() == 0 && eng_port.size() == 0 && exp_q[0].size() == 0 &&
           exp_q[1].size() == 0 && exp_q[2].size() == 0 && exp_q[3].size() == 0;
  endfunction

  task automatic drain(input string req);
    int n = 0;
    while (!all_empty() && n < 3000) begin @(negedge clk); #2; n++; end
    chk(all_empty(), req, 80'(n), 80'(0));
  endtask

  always @(negedge clk) if (run) begin
    in_vld = send_q.size() > 0;
    in_pkt = in_vld ? send_q[0] : '0;
    lk_req_rdy = rand_busy ? 1'($urandom % 2) : 1'b1;
    lk_rsp_vld = eng_port.size() > 0 && !rsp_hold && eng_due[0] <= cyc;
    lk_rsp_port = eng_port.size() > 0 ? eng_port[0] : 2'd0;
    out_take = rand_take ? 4'($urandom) : ~take_block;
    #1;
    if (prev_req_stall)  // R7
      chk(lk_req_vld && lk_req_addr == prev_addr, "R7", 80'(lk_req_addr), 80'(prev_addr));
    for (int p = 0; p < 4; p++)
      if (prev_out_stall[p])  // R11
        chk(out_vld[p] && out_pkt[p*80 +: 80] == prev_out[p], "R11", out_pkt[p*80 +: 80], prev_out[p]);
    if (in_vld && !in_rdy) stall_cnt++;
    if (in_vld && in_rdy) begin
      exp_q[route_of(in_pkt[79:64])].push_back(in_pkt);
      addr_q.push_back(in_pkt[79:64]);
      void'(send_q.pop_front());
      acc_cnt++;
    end
    if (lk_req_vld && lk_req_rdy) begin
      logic [15:0] ea;
      ea = addr_q.size() > 0 ? addr_q.pop_front() : 16'hxxxx;
      chk(lk_req_addr == ea, "R2/R3", 80'(lk_req_addr), 80'(ea));
      eng_port.push_back(route_of(lk_req_addr));
      eng_due.push_back(cyc + 1 + (rand_lat ? int'($urandom % 5) : 0));
      req_cnt++;
    end
    if (lk_rsp_vld && lk_rsp_rdy) begin
      void'(eng_port.pop_front()); void'(eng_due.pop_front());
    end
    if (lk_rsp_vld && !lk_rsp_rdy && lk_rsp_port == 2'd0 && take_block[0]) seen_stall = 1;
    for (int p = 0; p < 4; p++)
      if (out_vld[p] && out_take[p]) begin
        logic [79:0] e;
        e = exp_q[p].size() > 0 ? exp_q[p].pop_front() : 80'hx;
        chk(out_pkt[p*80 +: 80] === e, $sformatf("R4/R5 port%0d", p), out_pkt[p*80 +: 80], e);
      end
    prev_req_stall = lk_req_vld && !lk_req_rdy;
    prev_addr = lk_req_addr;
    for (int p = 0; p < 4; p++) begin
      prev_out_stall[p] = out_vld[p] && !out_take[p];
      prev_out[p] = out_pkt[p*80 +: 80];
    end
    cyc++;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(in_rdy && !lk_req_vld && out_vld == 0 && !lk_rsp_rdy, "R1",
        80'({in_rdy, lk_req_vld, out_vld, lk_rsp_rdy}), 80'({1'b1, 1'b0, 4'b0, 1'b0}));
    // R9 table passthrough
    tbl_wr = 1; tbl_idx = 12'hA5C; tbl_dat = 12'h3F1; #1;
    chk(lk_tbl_wr && lk_tbl_idx == 12'hA5C && lk_tbl_dat == 12'h3F1, "R9",
        80'({lk_tbl_wr, lk_tbl_idx, lk_tbl_dat}), 80'({1'b1, 12'hA5C, 12'h3F1}));
    tbl_wr = 0; tbl_idx = 12'h123; tbl_dat = 12'hFED; #1;
    chk(!lk_tbl_wr && lk_tbl_idx == 12'h123 && lk_tbl_dat == 12'hFED, "R9",
        80'({lk_tbl_wr, lk_tbl_idx, lk_tbl_dat}), 80'({1'b0, 12'h123, 12'hFED}));
    @(negedge clk);
    run = 1;

    // R10 back-to-back throughput
    for (int i = 0; i < 100; i++) send(16'($urandom), {32'(i), 32'($urandom)});
    stall_cnt = 0;
    drain("R10 drain");
    chk(stall_cnt <= 10, "R10", 80'(stall_cnt), 80'(10));

    // R5 random stalls and latencies
    rand_busy = 1; rand_lat = 1; rand_take = 1;
    for (int i = 0; i < 200; i++) send(16'($urandom), {32'(1000 + i), 32'($urandom)});
    drain("R5");
    rand_busy = 0; rand_lat = 0; rand_take = 0;

    // R6 blocked output port
    take_block = 4'b0001;
    for (int i = 0; i < 8; i++) send(16'(i << 10), {32'(2000 + i), 32'hC0FFEE00});
    repeat (40) @(negedge clk);
    #2;
    chk(seen_stall && out_vld[0], "R6 stall", 80'({seen_stall, out_vld[0]}), 80'(2'b11));
    chk(exp_q[0].size() == 8, "R6 held", 80'(exp_q[0].size()), 80'(8));
    take_block = 4'b0000;
    drain("R6 delivered");

    // R8 pending bound
    rsp_hold = 1; req_cnt = 0; acc_cnt = 0;
    for (int i = 0; i < 10; i++) send(16'($urandom), {32'(3000 + i), 32'h0});
    repeat (30) @(negedge clk);
    #2;
    chk(req_cnt == 4, "R8 requests", 80'(req_cnt), 80'(4));
    chk(acc_cnt == 6, "R8 accepted", 80'(acc_cnt), 80'(6));
    rsp_hold = 0;
    drain("R8 drain");

    summary();
    $finish;
  end
endmodule